// File: doc/BRIEF.md
# Dual-Mode Processor Timer

This block is the timer attached to one processor slot. In its normal counter mode it counts timebase ticks in a 22-bit field, compares the field with a programmable limit and, on a match, sets a sticky reached flag, raises a level interrupt and starts again from zero. A limit of zero turns the match off, so the field runs freely and wraps at its maximum. The tick input is a one-cycle pulse from a shared 500 ns timebase.

Setting the mode bit turns the same count register into a 64-bit user counter. Software starts and stops it through a status bit and reads or loads it as two 32-bit words. In this mode the timer never interrupts. When the mode bit is cleared, the counter stops and only the counter-field bits of the value are kept.

The bus is a simple word-addressed port. Read data is combinational and valid while `rd_en` is high. The side effects of a read and a write take place at the clock edge that ends the access.

Top module: `proc_timer`

## Requirements
- R1: In counter mode, each cycle with `tick` high adds one to the count field, which is bits 30:9 of a read at offset 1, so the read value grows by 0x200. With no tick and no write, the count does not change.
- R2: In counter mode with a zero limit, a tick at a count field of 0x3FFFFF (read 0x7FFFFE00) makes the field 0. The reached flag is not set.
- R3: In counter mode with a nonzero limit L in field units, a tick while the field equals L-1 makes the field 0 and sets the reached flag (bit 31 at offsets 0 and 1) and `irq`. In user mode `irq` stays low.
- R4: A zero limit never sets the reached flag or `irq`.
- R5: A write at offset 0 in counter mode loads the limit from wdata bits 30:9, zeroes the count and clears reached and `irq`. The write takes precedence over a tick in the same cycle.
- R6: A write at offset 2 in counter mode loads the limit and leaves the count, reached and `irq` unchanged. In counter mode, offset 0 reads {reached, limit, 9 zero bits}.
- R7: In user mode, offset 0 holds the high word and offset 1 the low word of a 64-bit value. While running, each tick adds 0x200 to it, with a carry into the high word. A write to either word loads that word and clears reached.
- R8: In user mode, writing 1 to bit 0 at offset 3 starts a stopped counter and writing 0 stops a running one. A stopped counter holds its value. Offset 3 reads the running bit in bit 0.
- R9: Writing 1 to bit 0 at offset 4 enters user mode: the counter is stopped, the value is kept and `irq` is cleared. Writing 0 leaves user mode: the counter stops and every bit outside 30:9 is zeroed. Offset 4 reads the mode bit in bit 0.
- R10: A read at offset 0 in counter mode returns the current flag and afterwards clears reached and `irq`. A match in the same cycle takes precedence.
- R11: In counter mode, writes at offsets 1 and 3 are ignored. In user mode, writes at offset 2 are ignored. Reads at offsets 5 to 7 return zero.
- R12: After reset the limit, count, reached flag, mode bit and running bit are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when rd_en is low |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is the free-running wrap. Counting up to a field of 0x3FFFFF would take four million ticks. Instead, the stimulus enters user mode, writes an all-ones low word, and leaves user mode, which keeps bits 30:9. One tick then has to produce zero with no reached flag. The cycle in which a clearing read and a match happen together is made by raising `tick` during the read at offset 0.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   typedef enum logic [2:0] {
      OFS_LIMIT      = 3'd0,
      OFS_COUNT      = 3'd1,
      OFS_LIMIT_KEEP = 3'd2,
      OFS_USTAT      = 3'd3,
      OFS_MODE       = 3'd4
   } ptmr_ofs_e;

   typedef struct packed {
      logic lim;
      logic cnt;
      logic lim_keep;
      logic ustat;
      logic mode;
   } ptmr_sel_t;

endpackage

// File: rtl/ptmr_decode.sv
module ptmr_decode
   import ptmr_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   output ptmr_sel_t         wsel,
   output ptmr_sel_t         rsel
);

   ptmr_sel_t hit;

   always_comb begin
      hit.lim      = (addr == ADDR_W'(OFS_LIMIT));
      hit.cnt      = (addr == ADDR_W'(OFS_COUNT));
      hit.lim_keep = (addr == ADDR_W'(OFS_LIMIT_KEEP));
      hit.ustat    = (addr == ADDR_W'(OFS_USTAT));
      hit.mode     = (addr == ADDR_W'(OFS_MODE));
   end

   assign wsel = wr_en ? hit : '0;
   assign rsel = rd_en ? hit : '0;

endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
   import ptmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int FRAC_W = 9,
   parameter int USER_W = 64,
   localparam int CW    = DATA_W - 1 - FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  ptmr_sel_t         wsel,
   input  logic              rclr,
   input  logic [DATA_W-1:0] wdata,
   output logic [USER_W-1:0] acc_q,
   output logic [CW-1:0]     lim_q,
   output logic              rch_q,
   output logic              irq_q,
   output logic              usr_q,
   output logic              run_q
);

   localparam logic [USER_W-1:0] STEP       = USER_W'(1) << FRAC_W;
   localparam logic [USER_W-1:0] FIELD_MASK = ((USER_W'(1) << CW) - USER_W'(1)) << FRAC_W;
   localparam logic [CW-1:0]     CNT_MAX    = {CW{1'b1}};

   logic [CW-1:0]     cnt_q;
   logic [USER_W-1:0] acc_d, acc_hi_wr, acc_lo_wr;
   logic [CW-1:0]     lim_d;
   logic              rch_d, irq_d, usr_d, run_d;
   logic              match;

   assign cnt_q = acc_q[FRAC_W +: CW];
   assign match = (lim_q != '0) && (cnt_q == lim_q - 1'b1);

   generate
      if (USER_W > DATA_W) begin : g_split
         assign acc_hi_wr = {wdata[USER_W-DATA_W-1:0], acc_q[DATA_W-1:0]};
         assign acc_lo_wr = {acc_q[USER_W-1:DATA_W], wdata};
      end else begin : g_single
         assign acc_hi_wr = acc_q;
         assign acc_lo_wr = wdata;
      end
   endgenerate

   always_comb begin
      acc_d = acc_q;
      lim_d = lim_q;
      rch_d = rch_q;
      irq_d = irq_q;
      usr_d = usr_q;
      run_d = run_q;

      if (!usr_q && rclr) begin
         rch_d = 1'b0;
         irq_d = 1'b0;
      end

      if (tick) begin
         if (!usr_q) begin
            if (match) begin
               acc_d = '0;
               rch_d = 1'b1;
               irq_d = 1'b1;
            end else if (cnt_q == CNT_MAX) begin
               acc_d = '0;
            end else begin
               acc_d = acc_q + STEP;
            end
         end else if (run_q) begin
            acc_d = acc_q + STEP;
         end
      end

      if (!usr_q) begin
         if (wsel.lim) begin
            lim_d = wdata[FRAC_W +: CW];
            acc_d = '0;
            rch_d = 1'b0;
            irq_d = 1'b0;
         end else if (wsel.lim_keep) begin
            lim_d = wdata[FRAC_W +: CW];
         end
      end else begin
         if (wsel.lim) begin
            acc_d = acc_hi_wr;
            rch_d = 1'b0;
         end else if (wsel.cnt) begin
            acc_d = acc_lo_wr;
            rch_d = 1'b0;
         end else if (wsel.ustat) begin
            if (wdata[0] && !run_q) begin
               run_d = 1'b1;
            end else if (!wdata[0] && run_q) begin
               run_d = 1'b0;
            end
         end
      end

      if (wsel.mode) begin
         if (wdata[0] && !usr_q) begin
            usr_d = 1'b1;
            run_d = 1'b0;
            irq_d = 1'b0;
         end else if (!wdata[0] && usr_q) begin
            usr_d = 1'b0;
            run_d = 1'b0;
            acc_d = acc_q & FIELD_MASK;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         lim_q <= '0;
         rch_q <= 1'b0;
         irq_q <= 1'b0;
         usr_q <= 1'b0;
         run_q <= 1'b0;
      end else begin
         acc_q <= acc_d;
         lim_q <= lim_d;
         rch_q <= rch_d;
         irq_q <= irq_d;
         usr_q <= usr_d;
         run_q <= run_d;
      end
   end

endmodule

// File: rtl/ptmr_rdmux.sv
module ptmr_rdmux
   import ptmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int FRAC_W = 9,
   parameter int USER_W = 64,
   localparam int CW    = DATA_W - 1 - FRAC_W
) (
   input  ptmr_sel_t         rsel,
   input  logic [USER_W-1:0] acc_q,
   input  logic [CW-1:0]     lim_q,
   input  logic              rch_q,
   input  logic              usr_q,
   input  logic              run_q,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] hi_word, lo_word, lim_word, cnt_word;

   generate
      if (USER_W > DATA_W) begin : g_hi
         assign hi_word = DATA_W'(acc_q[USER_W-1:DATA_W]);
      end else begin : g_nohi
         assign hi_word = '0;
      end
   endgenerate

   assign lo_word  = acc_q[DATA_W-1:0];
   assign lim_word = {rch_q, lim_q, {FRAC_W{1'b0}}};
   assign cnt_word = {rch_q, acc_q[FRAC_W +: CW], {FRAC_W{1'b0}}};

   always_comb begin
      rdata = '0;
      if (rsel.lim) begin
         rdata = usr_q ? hi_word : lim_word;
      end else if (rsel.cnt) begin
         rdata = usr_q ? lo_word : cnt_word;
      end else if (rsel.lim_keep) begin
         rdata = usr_q ? '0 : lim_word;
      end else if (rsel.ustat) begin
         rdata = DATA_W'(run_q);
      end else if (rsel.mode) begin
         rdata = DATA_W'(usr_q);
      end
   end

endmodule

// File: rtl/proc_timer.sv
module proc_timer
   import ptmr_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32,
   parameter int FRAC_W = 9,
   parameter int USER_W = 64,
   localparam int CW    = DATA_W - 1 - FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("proc_timer: ADDR_W must be at least 3");
      end
      if (FRAC_W < 1 || FRAC_W > DATA_W - 2) begin : g_bad_frac
         $error("proc_timer: FRAC_W out of range");
      end
      if (USER_W < DATA_W || USER_W > 2 * DATA_W) begin : g_bad_user
         $error("proc_timer: USER_W must lie between DATA_W and 2*DATA_W");
      end
   endgenerate

   ptmr_sel_t         wsel, rsel;
   logic [USER_W-1:0] acc_q;
   logic [CW-1:0]     lim_q;
   logic              rch_q, irq_q, usr_q, run_q;

   ptmr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr  (addr),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .wsel  (wsel),
      .rsel  (rsel)
   );

   ptmr_core #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .USER_W(USER_W)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .wsel  (wsel),
      .rclr  (rsel.lim),
      .wdata (wdata),
      .acc_q (acc_q),
      .lim_q (lim_q),
      .rch_q (rch_q),
      .irq_q (irq_q),
      .usr_q (usr_q),
      .run_q (run_q)
   );

   ptmr_rdmux #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .USER_W(USER_W)) u_rd (
      .rsel  (rsel),
      .acc_q (acc_q),
      .lim_q (lim_q),
      .rch_q (rch_q),
      .usr_q (usr_q),
      .run_q (run_q),
      .rdata (rdata)
   );

   assign irq = irq_q;

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
   parameter int ADDR_W = 3,
   parameter int USER_W = 64,
   parameter int CW     = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic              irq,
   input logic [USER_W-1:0] acc_q,
   input logic [CW-1:0]     lim_q,
   input logic              rch_q,
   input logic              usr_q,
   input logic              run_q
);

   AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> rch_q); // R3

   AST_USER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      usr_q |-> !irq); // R3

   AST_ZERO_LIMIT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rch_q) |-> ($past(lim_q) != '0 && !$past(usr_q))); // R4

   AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_en) |=> $stable(acc_q)); // R1

   AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_q && !run_q && !wr_en) |=> $stable(acc_q)); // R8

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == '0 && !usr_q && !tick && !wr_en) |=> (!irq && !rch_q)); // R10

endmodule

bind proc_timer ptmr_chk #(.ADDR_W(ADDR_W), .USER_W(USER_W), .CW(CW)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .tick  (tick),
   .wr_en (wr_en),
   .rd_en (rd_en),
   .addr  (addr),
   .irq   (irq),
   .acc_q (acc_q),
   .lim_q (lim_q),
   .rch_q (rch_q),
   .usr_q (usr_q),
   .run_q (run_q)
);

// File: tb/sim_proc_timer.sv
`timescale 1ns/1ps
module sim_proc_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   proc_timer u0 (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata),
      .irq   (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic irq_chk(input string req, input logic exp);
      chk(req, {31'b0, irq}, {31'b0, exp});
   endtask

   task automatic t_reset;
      irq_chk("R12", 1'b0);
      rd_chk("R12", 3'd0, 32'h0);
      rd_chk("R12", 3'd1, 32'h0);
      rd_chk("R12", 3'd3, 32'h0);
      rd_chk("R12", 3'd4, 32'h0);
   endtask

   task automatic t_tick_basic;
      ticks(3);
      rd_chk("R1", 3'd1, 32'h0000_0600);
      @(negedge clk);
      @(negedge clk);
      rd_chk("R1", 3'd1, 32'h0000_0600);
   endtask

   task automatic t_match;
      wr(3'd0, 32'h0000_0A00);
      rd_chk("R5", 3'd1, 32'h0);
      ticks(4);
      rd_chk("R3", 3'd1, 32'h0000_0800);
      irq_chk("R3", 1'b0);
      ticks(1);
      rd_chk("R3", 3'd1, 32'h8000_0000);
      irq_chk("R3", 1'b1);
   endtask

   task automatic t_rdclr;
      logic [31:0] d;
      rd_chk("R10", 3'd0, 32'h8000_0A00);
      irq_chk("R10", 1'b0);
      rd_chk("R10", 3'd1, 32'h0);
      ticks(4);
      tick = 1'b1;
      rd(3'd0, d);
      tick = 1'b0;
      chk("R10", d, 32'h0000_0A00);
      irq_chk("R10", 1'b1);
      rd_chk("R10", 3'd1, 32'h8000_0000);
      rd_chk("R10", 3'd0, 32'h8000_0A00);
      irq_chk("R10", 1'b0);
   endtask

   task automatic t_keep;
      wr(3'd0, 32'h0000_0A00);
      ticks(2);
      wr(3'd2, 32'h0000_1400);
      rd_chk("R6", 3'd1, 32'h0000_0400);
      rd_chk("R6", 3'd0, 32'h0000_1400);
      ticks(7);
      rd_chk("R6", 3'd1, 32'h0000_1200);
      irq_chk("R6", 1'b0);
      ticks(1);
      irq_chk("R3", 1'b1);
      wr(3'd2, 32'h0000_0800);
      rd_chk("R6", 3'd1, 32'h8000_0000);
      irq_chk("R6", 1'b1);
      wr(3'd0, 32'h0);
      irq_chk("R5", 1'b0);
      rd_chk("R5", 3'd1, 32'h0);
      rd_chk("R5", 3'd0, 32'h0);
   endtask

   task automatic t_free;
      ticks(6);
      rd_chk("R4", 3'd1, 32'h0000_0C00);
      irq_chk("R4", 1'b0);
   endtask

   task automatic t_ignore;
      wr(3'd1, 32'h1234_5600);
      rd_chk("R11", 3'd1, 32'h0000_0C00);
      wr(3'd3, 32'h1);
      rd_chk("R11", 3'd3, 32'h0);
      rd_chk("R11", 3'd5, 32'h0);
      rd_chk("R11", 3'd6, 32'h0);
      rd_chk("R11", 3'd7, 32'h0);
   endtask

   task automatic t_user;
      wr(3'd4, 32'h1);
      rd_chk("R9", 3'd4, 32'h1);
      rd_chk("R9", 3'd3, 32'h0);
      rd_chk("R9", 3'd1, 32'h0000_0C00);
      rd_chk("R7", 3'd0, 32'h0);
      ticks(2);
      rd_chk("R8", 3'd1, 32'h0000_0C00);
      wr(3'd3, 32'h1);
      rd_chk("R8", 3'd3, 32'h1);
      ticks(2);
      rd_chk("R8", 3'd1, 32'h0000_1000);
      wr(3'd0, 32'h1);
      wr(3'd1, 32'hFFFF_FE00);
      ticks(1);
      rd_chk("R7", 3'd1, 32'h0);
      rd_chk("R7", 3'd0, 32'h2);
      irq_chk("R3", 1'b0);
      wr(3'd3, 32'h0);
      ticks(1);
      rd_chk("R8", 3'd1, 32'h0);
      wr(3'd3, 32'h1);
      wr(3'd4, 32'h0);
      rd_chk("R9", 3'd4, 32'h0);
      rd_chk("R9", 3'd1, 32'h0);
      wr(3'd4, 32'h1);
      rd_chk("R9", 3'd3, 32'h0);
      rd_chk("R9", 3'd0, 32'h0);
      wr(3'd4, 32'h0);
   endtask

   task automatic t_reach_wrap;
      wr(3'd0, 32'h0000_0400);
      ticks(2);
      irq_chk("R3", 1'b1);
      wr(3'd2, 32'h0);
      rd_chk("R6", 3'd1, 32'h8000_0000);
      wr(3'd4, 32'h1);
      irq_chk("R9", 1'b0);
      wr(3'd2, 32'h0000_0800);
      wr(3'd0, 32'h5);
      wr(3'd1, 32'hFFFF_FFFF);
      rd_chk("R7", 3'd1, 32'hFFFF_FFFF);
      rd_chk("R7", 3'd0, 32'h5);
      wr(3'd4, 32'h0);
      rd_chk("R7", 3'd1, 32'h7FFF_FE00);
      rd_chk("R11", 3'd0, 32'h0);
      ticks(1);
      rd_chk("R2", 3'd1, 32'h0);
      irq_chk("R2", 1'b0);
      rd_chk("R4", 3'd0, 32'h0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #20000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tick_basic();
      t_match();
      t_rdclr();
      t_keep();
      t_free();
      t_ignore();
      t_user();
      t_reach_wrap();
      finish_run();
   end

endmodule